// File: doc/BRIEF.md
# PLL Feedback Multiplier Slide Controller

This block changes the feedback multiplier N of a PLL that is already running, without letting the loop lose lock. Instead of stopping the PLL, it uses the PLL's own slowdown and dynamic-ramp circuits. The controller first puts the PLL into slowdown, then writes the new N with the other divider fields untouched, and then starts the ramp. It waits for the PLL to report that the ramp has finished. When that happens, or when a 500 microsecond limit runs out, it releases both control bits in the same cycle.

The ramp-done status comes from the PLL clock domain, so it passes through two flip-flops before the state machine looks at it. Time is measured in microsecond tick pulses supplied by the system. The block also turns the reference frequency, given in kHz, into the two 8-bit ramp step sizes the PLL needs, and raises an error flag for a reference frequency it does not support. The ramp itself is analog behaviour of the PLL and is not part of this block.

Top module: `ndiv_slide_ctrl`

## Requirements
- R1: A request whose `req_n` equals `cur_n` makes `done` high for exactly the next cycle. It does not raise `slowdown_en`, `ramp_en`, `n_wr` or `busy`.
- R2: A request with a different N sets `slowdown_en` and `busy` one cycle later, with `ramp_en` and `n_wr` still low. In the following cycle `n_wr` pulses for one cycle with `n_wr_data` equal to the requested N, while `slowdown_en` stays high.
- R3: `ramp_en` rises in the cycle right after the `n_wr` pulse, and `slowdown_en` stays high.
- R4: `ramp_done_raw` passes through two synchronizing flops. If it goes high before clock edge k, `ramp_en` is still high after edges k and k+1. After edge k+2, `slowdown_en`, `ramp_en` and `busy` are all low and `done` is high for one cycle.
- R5: The controller counts `us_tick` pulses while it waits for the ramp. If the synchronized ramp-done flag has not been seen after `TIMEOUT_US` (default 500) pulses, it clears `slowdown_en` and `ramp_en` together, sets `timeout_err` and does not pulse `done`.
- R6: `timeout_err` stays set until the next request is accepted in idle, and that request clears it.
- R7: A request that arrives while `busy` is high is ignored. It causes no further `n_wr` pulse and does not change `n_wr_data`.
- R8: One cycle after `ref_khz` changes, the step outputs follow it: 12000, 12800 and 13000 give `step_a`=0x2B and `step_b`=0x0B. 19200 gives 0x12 and 0x08. 38400 gives 0x04 and 0x05. Any other value gives `ref_err`=1 with both steps 0.
- R9: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request pulse to slide to `req_n` |
| req_n | input | N_W | Target feedback multiplier |
| cur_n | input | N_W | Multiplier currently programmed |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| ramp_done_raw | input | 1 | Ramp-finished status from the PLL domain |
| ref_khz | input | 16 | Reference frequency in kHz |
| slowdown_en | output | 1 | PLL slowdown mode control |
| ramp_en | output | 1 | PLL dynamic ramp enable |
| n_wr | output | 1 | One-cycle write strobe for the N field |
| n_wr_data | output | N_W | Value written to the N field |
| busy | output | 1 | A slide is in progress |
| done | output | 1 | One-cycle pulse when a slide or no-op completes |
| timeout_err | output | 1 | The last slide timed out |
| step_a | output | 8 | Ramp step size A |
| step_b | output | 8 | Ramp step size B |
| ref_err | output | 1 | Unsupported reference frequency |

## Verification
The assertions check the ordering of the handshake on every cycle. The N write only happens while slowdown is on and the ramp is off, and the ramp only starts after a write. The two control bits always fall together. The no-op path never touches a control bit. While polling, `n_wr_data` does not change, and the error flag and the expired timer stay set. Only the bench scenarios can show the exact cycle counts: the two-flop synchronizer latency, the timeout landing on exactly the 500th tick, the step-table values, and that the error clears on the next request.

// File: rtl/ndiv_slide_pkg.sv
package ndiv_slide_pkg;

  localparam int REF_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOW = 2'd1,
    ST_WRN  = 2'd2,
    ST_POLL = 2'd3
  } slide_st_e;

  typedef struct packed {
    logic       ok;
    logic [7:0] a;
    logic [7:0] b;
  } ramp_step_t;

  // Ramp step sizes depend on the reference frequency (kHz).
  function automatic ramp_step_t step_for_ref(input logic [REF_W-1:0] ref_khz);
    ramp_step_t r;
    r = '0;
    case (ref_khz)
      16'd12000, 16'd12800, 16'd13000: r = '{ok: 1'b1, a: 8'h2B, b: 8'h0B};
      16'd19200:                       r = '{ok: 1'b1, a: 8'h12, b: 8'h08};
      16'd38400:                       r = '{ok: 1'b1, a: 8'h04, b: 8'h05};
      default:                         r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ndiv_sync2.sv
module ndiv_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/ndiv_us_timer.sv
module ndiv_us_timer #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt <= '0;
    else if (clr)                       cnt <= '0;
    else if (run && tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  AST_EXPIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !clr |=> expired); // R5
endmodule

// File: rtl/ndiv_slide_ctrl.sv
module ndiv_slide_ctrl
  import ndiv_slide_pkg::*;
#(
  parameter int N_W        = 8,
  parameter int TIMEOUT_US = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [N_W-1:0]   req_n,
  input  logic [N_W-1:0]   cur_n,
  input  logic             us_tick,
  input  logic             ramp_done_raw,
  input  logic [REF_W-1:0] ref_khz,
  output logic             slowdown_en,
  output logic             ramp_en,
  output logic             n_wr,
  output logic [N_W-1:0]   n_wr_data,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [7:0]       step_a,
  output logic [7:0]       step_b,
  output logic             ref_err
);

  slide_st_e      st;
  logic [N_W-1:0] tgt;
  logic           done_s;
  logic           expired;

  // Named events for the assertions
  logic ev_noop, ev_accept, ev_ok, ev_tmo;
  assign ev_noop   = (st == ST_IDLE) && req && (req_n == cur_n);
  assign ev_accept = (st == ST_IDLE) && req && (req_n != cur_n);
  assign ev_ok     = (st == ST_POLL) && done_s;
  assign ev_tmo    = (st == ST_POLL) && !done_s && expired;

  ndiv_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ramp_done_raw),
    .q     (done_s)
  );

  ndiv_us_timer #(.LIMIT(TIMEOUT_US)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st != ST_POLL),
    .run     (st == ST_POLL),
    .tick    (us_tick),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      tgt         <= '0;
      slowdown_en <= 1'b0;
      ramp_en     <= 1'b0;
      n_wr        <= 1'b0;
      n_wr_data   <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      n_wr <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (ev_noop) begin
            done        <= 1'b1;
            timeout_err <= 1'b0;
          end else if (ev_accept) begin
            tgt         <= req_n;
            slowdown_en <= 1'b1;
            busy        <= 1'b1;
            timeout_err <= 1'b0;
            st          <= ST_SLOW;
          end
        end
        ST_SLOW: begin
          n_wr      <= 1'b1;
          n_wr_data <= tgt;
          st        <= ST_WRN;
        end
        ST_WRN: begin
          ramp_en <= 1'b1;
          st      <= ST_POLL;
        end
        ST_POLL: begin
          if (ev_ok || ev_tmo) begin
            slowdown_en <= 1'b0;
            ramp_en     <= 1'b0;
            busy        <= 1'b0;
            done        <= ev_ok;
            timeout_err <= ev_tmo;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Step size lookup, registered
  ramp_step_t stp;
  assign stp = step_for_ref(ref_khz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_a  <= '0;
      step_b  <= '0;
      ref_err <= 1'b0;
    end else begin
      step_a  <= stp.a;
      step_b  <= stp.b;
      ref_err <= !stp.ok;
    end
  end

  AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_noop |=> done && !slowdown_en && !busy && !n_wr); // R1
  AST_WR_IN_SLOWDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    n_wr |-> slowdown_en && !ramp_en); // R2
  AST_RAMP_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en) |-> $past(n_wr) && slowdown_en); // R3
  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slowdown_en) |-> $fell(ramp_en)); // R4
  AST_TMO_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> timeout_err && !done && !ramp_en); // R5
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err && !req |=> timeout_err); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POLL) |=> $stable(n_wr_data) && !n_wr); // R7

endmodule

// File: tb/ndiv_slide_ctrl_test.sv
module ndiv_slide_ctrl_test;
  localparam int N_W = 8;
  localparam int TMO = 500;
  localparam time CYC = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, us_tick = 1'b0, ramp_done_raw = 1'b0;
  logic [N_W-1:0] req_n = '0, cur_n = '0;
  logic [15:0] ref_khz = 16'd12000;
  logic slowdown_en, ramp_en, n_wr, busy, done, timeout_err, ref_err;
  logic [N_W-1:0] n_wr_data;
  logic [7:0] step_a, step_b;

  int tests = 0, fails = 0;
  int tick_div = 0, ticks_ramp = 0, nwr_cnt = 0;
  bit tick_on = 1'b0;

  always #(CYC/2) clk = ~clk;

  ndiv_slide_ctrl #(.N_W(N_W), .TIMEOUT_US(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_n(req_n), .cur_n(cur_n),
    .us_tick(us_tick), .ramp_done_raw(ramp_done_raw), .ref_khz(ref_khz),
    .slowdown_en(slowdown_en), .ramp_en(ramp_en), .n_wr(n_wr),
    .n_wr_data(n_wr_data), .busy(busy), .done(done),
    .timeout_err(timeout_err), .step_a(step_a), .step_b(step_b),
    .ref_err(ref_err)
  );

  // Microsecond tick every 5 cycles; count ticks seen while ramping
  always @(negedge clk) begin
    if (tick_on) begin
      tick_div = (tick_div == 4) ? 0 : tick_div + 1;
      us_tick = (tick_div == 0);
      if (us_tick && ramp_en) ticks_ramp++;
    end else us_tick = 1'b0;
    if (n_wr) nwr_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input logic [N_W-1:0] cur, input logic [N_W-1:0] nw);
    cur_n = cur; req_n = nw; req = 1'b1;
    cyc(1);
    req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 slowdown", slowdown_en, 0); chk("R9 ramp", ramp_en, 0);
    chk("R9 busy", busy, 0); chk("R9 done", done, 0);
    chk("R9 err", timeout_err, 0); chk("R9 nwr", n_wr, 0);
  endtask

  task automatic t_noop();
    issue(8'd50, 8'd50);
    chk("R1 done", done, 1); chk("R1 slowdown", slowdown_en, 0);
    chk("R1 ramp", ramp_en, 0); chk("R1 busy", busy, 0); chk("R1 nwr", n_wr, 0);
    cyc(1);
    chk("R1 done pulse", done, 0);
  endtask

  task automatic t_slide(input logic [N_W-1:0] cur, input logic [N_W-1:0] nw, input int dly);
    issue(cur, nw);
    chk("R2 slowdown", slowdown_en, 1); chk("R2 busy", busy, 1);
    chk("R2 ramp low", ramp_en, 0); chk("R2 no early wr", n_wr, 0);
    cyc(1);
    chk("R2 nwr", n_wr, 1); chk("R2 data", n_wr_data, nw);
    chk("R2 ramp low at wr", ramp_en, 0);
    cyc(1);
    chk("R3 ramp", ramp_en, 1); chk("R3 slowdown held", slowdown_en, 1);
    chk("R2 nwr pulse", n_wr, 0);
    cyc(dly);
    ramp_done_raw = 1'b1;
    cyc(2);
    chk("R4 sync latency", ramp_en, 1);
    cyc(1);
    chk("R4 done", done, 1); chk("R4 slowdown clr", slowdown_en, 0);
    chk("R4 ramp clr", ramp_en, 0); chk("R4 busy clr", busy, 0);
    ramp_done_raw = 1'b0;
    cyc(1);
    chk("R4 done pulse", done, 0);
    cyc(3);
  endtask

  task automatic t_timeout();
    ticks_ramp = 0;
    tick_on = 1'b1;
    issue(8'd30, 8'd90);
    for (int i = 0; i < TMO * 5 + 100 && (busy || i < 4); i++) cyc(1);
    chk("R5 ticks", ticks_ramp, TMO);
    chk("R5 err", timeout_err, 1); chk("R5 no done", done, 0);
    chk("R5 slowdown clr", slowdown_en, 0); chk("R5 ramp clr", ramp_en, 0);
    tick_on = 1'b0;
    cyc(20);
    chk("R6 err held", timeout_err, 1);
    issue(8'd90, 8'd90);
    chk("R6 err cleared", timeout_err, 0);
    cyc(2);
  endtask

  task automatic t_busy_ignore();
    nwr_cnt = 0;
    issue(8'd10, 8'd40);
    cyc(4);
    issue(8'd40, 8'd99);
    cyc(2);
    chk("R7 still ramping", ramp_en, 1);
    chk("R7 data kept", n_wr_data, 8'd40);
    ramp_done_raw = 1'b1;
    cyc(4);
    ramp_done_raw = 1'b0;
    chk("R7 single write", nwr_cnt, 1);
    chk("R7 data final", n_wr_data, 8'd40);
    chk("R7 idle", busy, 0);
    cyc(3);
  endtask

  task automatic t_steps(input logic [15:0] f, input logic [7:0] ea, input logic [7:0] eb, input logic ee);
    ref_khz = f;
    cyc(1);
    chk("R8 step_a", step_a, ea); chk("R8 step_b", step_b, eb);
    chk("R8 ref_err", ref_err, ee);
  endtask

  initial begin
    cyc(1);
    t_reset();
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_noop();
    t_slide(8'd20, 8'd60, 3);
    t_slide(8'd200, 8'd100, 10);
    t_busy_ignore();
    t_timeout();
    t_steps(16'd12000, 8'h2B, 8'h0B, 1'b0);
    t_steps(16'd12800, 8'h2B, 8'h0B, 1'b0);
    t_steps(16'd13000, 8'h2B, 8'h0B, 1'b0);
    t_steps(16'd19200, 8'h12, 8'h08, 1'b0);
    t_steps(16'd38400, 8'h04, 8'h05, 1'b0);
    t_steps(16'd26000, 8'h00, 8'h00, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule